// File: doc/BRIEF.md
# Two-Dimensional Parity Block Corrector

This block receives a fixed-length block of characters, one per cycle. Each character has a data word and one extra parity-track bit. The track bit gives the character even parity. The last character of every block is a longitudinal check word. It is the bitwise XOR of all the data words before it, and it carries its own track bit.

While the block streams in, the block computes two syndromes. The row syndrome has one bit per character and marks each character whose even parity fails. The column syndrome has one bit per data bit position and marks each position whose XOR over the whole block, check word included, is not zero. When a single bit has failed, the two syndromes locate it. A data bit is then inverted on the way out. An error in a track bit is absorbed and the data is left as it was. Every other non-zero pattern is reported as uncorrectable, and that block's data is passed through unchanged.

Blocks are stored in two alternating banks. Input may therefore arrive back to back with no gaps, and it never stalls. The corrected block is replayed one character per cycle. Its status flags are held for the whole replay.

Top module: `lrc2d_corrector`

## Requirements
- R1: While reset is held and after it is released, with no input, `out_valid_o`, `out_last_o`, `corrected_o` and `uncorrectable_o` are all low.
- R2: A block with no errors comes out with every data word unchanged and in input order. Both flags are low, and `out_last_o` is high only on the last character of the block.
- R3: The first output character of a block appears one cycle after its last input character is accepted, provided no earlier block is still being replayed. The block's `BLOCK_LEN` characters then follow on consecutive cycles.
- R4: When exactly one row fails and exactly one column fails, the data bit at that row and column is inverted, all other bits are unchanged, and `corrected_o` is high.
- R5: When exactly one row fails and no column fails, the error is taken to be in that character's parity-track bit. The data comes out unchanged and `corrected_o` is high.
- R6: A single flipped data bit inside the check word itself (the last character) is corrected in the same way as R4.
- R7: Any other non-zero syndrome pattern (two or more failing rows, or two or more failing columns) sets `uncorrectable_o`. The data comes out exactly as it was received.
- R8: When no row fails but at least one column fails (for example, a data bit and the track bit of the same character both flipped), the block is uncorrectable and passes through unchanged.
- R9: `corrected_o` and `uncorrectable_o` are never high together, both are low whenever `out_valid_o` is low, and they stay constant across all characters of one output block.
- R10: Blocks that arrive back to back with no idle cycles are each delivered in full and in order, with no block lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input character present this cycle |
| in_data_i | input | DATA_W | Data word of the input character |
| in_par_i | input | 1 | Parity-track bit of the input character (even parity with the data word) |
| out_valid_o | output | 1 | Output character present this cycle |
| out_data_o | output | DATA_W | Corrected (or passed-through) data word |
| out_last_o | output | 1 | Marks the last character of an output block |
| corrected_o | output | 1 | Block had one correctable error, held for the whole block |
| uncorrectable_o | output | 1 | Block had an error pattern that cannot be corrected, held for the whole block |

## Verification
The in-line assertions check, on every cycle, that the two status flags are exclusive, that both are silent between blocks, that both are stable within a block, that `out_last_o` only occurs on valid output, and that a finished block never overwrites one still waiting to be replayed. Only the bench's scenarios can show the main results. These are that the right bit is inverted for every one of the single-error positions, that track-bit errors leave the data untouched, that every two-error combination is flagged and passed through bit for bit, and that replay starts exactly one cycle after a block completes. The bench sweeps every single-error and every two-error position of the default block.

// File: rtl/lrc2d_pkg.sv
package lrc2d_pkg;
  typedef enum logic [1:0] {
    KIND_CLEAN    = 2'd0,
    KIND_FIX_DATA = 2'd1,
    KIND_FIX_PAR  = 2'd2,
    KIND_BAD      = 2'd3
  } blk_kind_e;
endpackage

// File: rtl/lrc2d_locate.sv
module lrc2d_locate
  import lrc2d_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BLOCK_LEN = 8
) (
  input  logic [BLOCK_LEN-1:0] row_syn_i,
  input  logic [DATA_W-1:0]    col_syn_i,
  output blk_kind_e            kind_o,
  output logic [((BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1)-1:0] row_o,
  output logic [((DATA_W > 1) ? $clog2(DATA_W) : 1)-1:0]       col_o
);
  localparam int IDX_W = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic row_one, col_one, row_none, col_none;

  assign row_one  = $onehot(row_syn_i);
  assign col_one  = $onehot(col_syn_i);
  assign row_none = (row_syn_i == '0);
  assign col_none = (col_syn_i == '0);

  always_comb begin
    if (row_none && col_none)     kind_o = KIND_CLEAN;
    else if (row_one && col_one)  kind_o = KIND_FIX_DATA;
    else if (row_one && col_none) kind_o = KIND_FIX_PAR;   // track bit hit
    else                          kind_o = KIND_BAD;
  end

  always_comb begin
    row_o = '0;
    for (int k = 0; k < BLOCK_LEN; k++)
      if (row_syn_i[k]) row_o = IDX_W'(k);
  end

  always_comb begin
    col_o = '0;
    for (int k = 0; k < DATA_W; k++)
      if (col_syn_i[k]) col_o = BIT_W'(k);
  end
endmodule

// File: rtl/lrc2d_ingress.sv
module lrc2d_ingress
  import lrc2d_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BLOCK_LEN = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [DATA_W-1:0]    in_data_i,
  input  logic                 in_par_i,
  input  logic                 take_i,
  output logic                 wr_en_o,
  output logic                 wr_bank_o,
  output logic [((BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1)-1:0] wr_idx_o,
  output logic                 pend_o,
  output logic                 pend_bank_o,
  output blk_kind_e            pend_kind_o,
  output logic [((BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1)-1:0] pend_row_o,
  output logic [((DATA_W > 1) ? $clog2(DATA_W) : 1)-1:0]       pend_col_o
);
  localparam int IDX_W = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [IDX_W-1:0]     cnt_q;
  logic                 bank_q;
  logic [BLOCK_LEN-1:0] row_acc_q, row_fin;
  logic [DATA_W-1:0]    col_acc_q, col_fin;
  logic                 row_fail, last_char, done;
  blk_kind_e            loc_kind;
  logic [IDX_W-1:0]     loc_row;
  logic [BIT_W-1:0]     loc_col;

  assign row_fail  = ^{in_data_i, in_par_i};
  assign last_char = (cnt_q == IDX_W'(BLOCK_LEN - 1));
  assign done      = in_valid_i && last_char;
  assign col_fin   = col_acc_q ^ in_data_i;

  always_comb begin
    for (int k = 0; k < BLOCK_LEN; k++)
      row_fin[k] = row_acc_q[k] | (row_fail && (cnt_q == IDX_W'(k)));
  end

  lrc2d_locate #(
    .DATA_W    (DATA_W),
    .BLOCK_LEN (BLOCK_LEN)
  ) i_locate (
    .row_syn_i (row_fin),
    .col_syn_i (col_fin),
    .kind_o    (loc_kind),
    .row_o     (loc_row),
    .col_o     (loc_col)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      bank_q    <= 1'b0;
      row_acc_q <= '0;
      col_acc_q <= '0;
    end else if (in_valid_i) begin
      if (last_char) begin
        cnt_q     <= '0;
        bank_q    <= ~bank_q;
        row_acc_q <= '0;
        col_acc_q <= '0;
      end else begin
        cnt_q     <= cnt_q + 1'b1;
        row_acc_q <= row_fin;
        col_acc_q <= col_fin;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o      <= 1'b0;
      pend_bank_o <= 1'b0;
      pend_kind_o <= KIND_CLEAN;
      pend_row_o  <= '0;
      pend_col_o  <= '0;
    end else if (done) begin
      pend_o      <= 1'b1;
      pend_bank_o <= bank_q;
      pend_kind_o <= loc_kind;
      pend_row_o  <= loc_row;
      pend_col_o  <= loc_col;
    end else if (take_i) begin
      pend_o      <= 1'b0;
    end
  end

  assign wr_en_o   = in_valid_i;
  assign wr_bank_o = bank_q;
  assign wr_idx_o  = cnt_q;

  // a finished block must never land on one still waiting for replay
  assert_no_pend_overrun_R10: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (done && pend_o) |-> take_i
  );
endmodule

// File: rtl/lrc2d_bank.sv
module lrc2d_bank #(
  parameter int DATA_W    = 8,
  parameter int BLOCK_LEN = 8,
  parameter int BANKS     = 2
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [((BANKS > 1) ? $clog2(BANKS) : 1)-1:0]         wr_bank_i,
  input  logic [((BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1)-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [((BANKS > 1) ? $clog2(BANKS) : 1)-1:0]         rd_bank_i,
  input  logic [((BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1)-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int BSEL_W = (BANKS > 1) ? $clog2(BANKS) : 1;

  logic [DATA_W-1:0] rd_word [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [BLOCK_LEN];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_bank_i == BSEL_W'(b))) mem_q[wr_idx_i] <= wr_data_i;
    end

    assign rd_word[b] = mem_q[rd_idx_i];
  end

  assign rd_data_o = rd_word[rd_bank_i];
endmodule

// File: rtl/lrc2d_corrector.sv
module lrc2d_corrector
  import lrc2d_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BLOCK_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_par_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic              corrected_o,
  output logic              uncorrectable_o
);
  localparam int IDX_W = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic             wr_en, wr_bank;
  logic [IDX_W-1:0] wr_idx;
  logic             pend, pend_bank;
  blk_kind_e        pend_kind;
  logic [IDX_W-1:0] pend_row;
  logic [BIT_W-1:0] pend_col;

  logic             rd_active_q, rd_bank_q;
  logic [IDX_W-1:0] rd_idx_q;
  blk_kind_e        cur_kind_q;
  logic [IDX_W-1:0] cur_row_q;
  logic [BIT_W-1:0] cur_col_q;

  logic              at_end, start, cont;
  logic [IDX_W-1:0]  sel_idx, sel_row;
  logic              sel_bank;
  blk_kind_e         sel_kind;
  logic [BIT_W-1:0]  sel_col;
  logic [DATA_W-1:0] rd_data, fix_mask;

  lrc2d_ingress #(
    .DATA_W    (DATA_W),
    .BLOCK_LEN (BLOCK_LEN)
  ) i_ingress (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_par_i    (in_par_i),
    .take_i      (start),
    .wr_en_o     (wr_en),
    .wr_bank_o   (wr_bank),
    .wr_idx_o    (wr_idx),
    .pend_o      (pend),
    .pend_bank_o (pend_bank),
    .pend_kind_o (pend_kind),
    .pend_row_o  (pend_row),
    .pend_col_o  (pend_col)
  );

  lrc2d_bank #(
    .DATA_W    (DATA_W),
    .BLOCK_LEN (BLOCK_LEN),
    .BANKS     (2)
  ) i_bank (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_bank_i (wr_bank),
    .wr_idx_i  (wr_idx),
    .wr_data_i (in_data_i),
    .rd_bank_i (sel_bank),
    .rd_idx_i  (sel_idx),
    .rd_data_o (rd_data)
  );

  assign at_end = !rd_active_q || (rd_idx_q == IDX_W'(BLOCK_LEN - 1));
  assign start  = at_end && pend;
  assign cont   = !at_end;

  always_comb begin
    if (start) begin
      sel_idx  = '0;
      sel_bank = pend_bank;
      sel_kind = pend_kind;
      sel_row  = pend_row;
      sel_col  = pend_col;
    end else begin
      sel_idx  = rd_idx_q + 1'b1;
      sel_bank = rd_bank_q;
      sel_kind = cur_kind_q;
      sel_row  = cur_row_q;
      sel_col  = cur_col_q;
    end
  end

  always_comb begin
    fix_mask = '0;
    if (sel_kind == KIND_FIX_DATA && sel_idx == sel_row) fix_mask[sel_col] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_active_q     <= 1'b0;
      rd_bank_q       <= 1'b0;
      rd_idx_q        <= '0;
      cur_kind_q      <= KIND_CLEAN;
      cur_row_q       <= '0;
      cur_col_q       <= '0;
      out_valid_o     <= 1'b0;
      out_data_o      <= '0;
      out_last_o      <= 1'b0;
      corrected_o     <= 1'b0;
      uncorrectable_o <= 1'b0;
    end else if (start || cont) begin
      rd_active_q     <= 1'b1;
      rd_bank_q       <= sel_bank;
      rd_idx_q        <= sel_idx;
      cur_kind_q      <= sel_kind;
      cur_row_q       <= sel_row;
      cur_col_q       <= sel_col;
      out_valid_o     <= 1'b1;
      out_data_o      <= rd_data ^ fix_mask;
      out_last_o      <= (sel_idx == IDX_W'(BLOCK_LEN - 1));
      corrected_o     <= (sel_kind == KIND_FIX_DATA) || (sel_kind == KIND_FIX_PAR);
      uncorrectable_o <= (sel_kind == KIND_BAD);
    end else begin
      rd_active_q     <= 1'b0;
      out_valid_o     <= 1'b0;
      out_last_o      <= 1'b0;
      corrected_o     <= 1'b0;
      uncorrectable_o <= 1'b0;
    end
  end

  assert_flags_excl_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !(corrected_o && uncorrectable_o)
  );

  assert_flags_idle_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (!corrected_o && !uncorrectable_o)
  );

  assert_last_valid_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o
  );

  assert_flags_stable_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(out_valid_o) && !$past(out_last_o))
      |-> ($stable(corrected_o) && $stable(uncorrectable_o))
  );
endmodule

// File: tb/test_lrc2d_corrector.sv
module test_lrc2d_corrector;
  localparam int DW   = 8;
  localparam int LEN  = 8;
  localparam int NPOS = LEN * (DW + 1);
  localparam int RING = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_par = 1'b0;
  logic          out_valid, out_last, corrected, uncorrectable;
  logic [DW-1:0] out_data;

  int checks = 0, fails = 0, cyc = 0;
  int sent = 0, recvd = 0, out_idx = 0;
  bit finished = 1'b0;

  logic [DW-1:0] blk_d [LEN];
  logic          blk_p [LEN];
  logic [DW-1:0] exp_d [RING][LEN];
  bit            exp_cor [RING];
  bit            exp_unc [RING];
  int            exp_last [RING];
  string         exp_req [RING];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lrc2d_corrector #(.DATA_W(DW), .BLOCK_LEN(LEN)) i_lrc2d_corrector (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .in_valid_i      (in_valid),
    .in_data_i       (in_data),
    .in_par_i        (in_par),
    .out_valid_o     (out_valid),
    .out_data_o      (out_data),
    .out_last_o      (out_last),
    .corrected_o     (corrected),
    .uncorrectable_o (uncorrectable)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // output monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!out_valid) begin
        check(!corrected && !uncorrectable && !out_last, "R9", "flags while idle",
              {corrected, uncorrectable, out_last}, 0);
      end else begin
        automatic int s = recvd % RING;
        if (out_idx == 0)
          check(cyc == exp_last[s] + 1, exp_req[s], "first char cycle (R3)",
                cyc, exp_last[s] + 1);
        check(out_data == exp_d[s][out_idx], exp_req[s], "data", out_data, exp_d[s][out_idx]);
        check(out_last == (out_idx == LEN - 1), "R2", "last marker",
              out_last, (out_idx == LEN - 1));
        check(corrected == exp_cor[s], exp_req[s], "corrected flag", corrected, exp_cor[s]);
        check(uncorrectable == exp_unc[s], exp_req[s], "uncorrectable flag",
              uncorrectable, exp_unc[s]);
        if (out_idx == LEN - 1) begin
          out_idx = 0;
          recvd++;
        end else begin
          out_idx++;
        end
      end
    end
  end

  task automatic build_clean(input int seed);
    logic [DW-1:0] acc = '0;
    for (int i = 0; i < LEN - 1; i++) begin
      blk_d[i] = DW'(seed * 37 + i * 91 + 5);
      acc ^= blk_d[i];
    end
    blk_d[LEN-1] = acc;
    for (int i = 0; i < LEN; i++) blk_p[i] = ^blk_d[i];
  endtask

  task automatic flip(input int pos);
    int r = pos / (DW + 1);
    int c = pos % (DW + 1);
    if (c == DW) blk_p[r] = ~blk_p[r];
    else         blk_d[r][c] = ~blk_d[r][c];
  endtask

  // expected data must be loaded into exp_d[sent%RING] by the caller
  task automatic send_block(input bit cor, input bit unc, input string req);
    int s = sent % RING;
    exp_cor[s] = cor;
    exp_unc[s] = unc;
    exp_req[s] = req;
    for (int i = 0; i < LEN; i++) begin
      @(posedge clk);
      #1;
      in_valid = 1'b1;
      in_data  = blk_d[i];
      in_par   = blk_p[i];
      if (i == LEN - 1) exp_last[s] = cyc + 1;
    end
    sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      in_valid = 1'b0;
    end
  endtask

  task automatic save_expected();
    for (int i = 0; i < LEN; i++) exp_d[sent % RING][i] = blk_d[i];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!out_valid && !out_last && !corrected && !uncorrectable, "R1", "outputs in reset",
          {out_valid, out_last, corrected, uncorrectable}, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_last && !corrected && !uncorrectable, "R1", "outputs after reset",
          {out_valid, out_last, corrected, uncorrectable}, 0);

    // R2: clean blocks, including all-zero and all-ones data words
    for (int k = 0; k < 4; k++) begin
      build_clean(k * 11);
      if (k == 2) for (int i = 0; i < LEN; i++) begin blk_d[i] = '0; blk_p[i] = 1'b0; end
      if (k == 3) begin
        for (int i = 0; i < LEN - 1; i++) blk_d[i] = '1;
        blk_d[LEN-1] = (LEN % 2 == 0) ? '1 : '0;
        for (int i = 0; i < LEN; i++) blk_p[i] = ^blk_d[i];
      end
      save_expected();
      send_block(1'b0, 1'b0, "R2");
    end
    idle(LEN + 2);

    // R3: spaced blocks, replay starts one cycle after the last input
    for (int k = 0; k < 3; k++) begin
      build_clean(100 + k);
      save_expected();
      send_block(1'b0, 1'b0, "R3");
      idle(k + 1);
    end
    idle(LEN + 2);

    // R4/R5/R6/R10: every single-error position, back to back
    for (int pos = 0; pos < NPOS; pos++) begin
      int r = pos / (DW + 1);
      int c = pos % (DW + 1);
      build_clean(pos + 7);
      save_expected();
      flip(pos);
      send_block(1'b1, 1'b0, (c == DW) ? "R5" : ((r == LEN - 1) ? "R6" : "R4"));
    end
    idle(LEN + 2);

    // R7/R8/R10: every two-error combination, data passes through untouched
    for (int a = 0; a < NPOS; a++) begin
      for (int b = a + 1; b < NPOS; b++) begin
        bit same_row = (a / (DW + 1)) == (b / (DW + 1));
        bit one_trk  = ((a % (DW + 1)) == DW) != ((b % (DW + 1)) == DW);
        build_clean(a * 3 + b);
        flip(a);
        flip(b);
        save_expected();
        send_block(1'b0, 1'b1, (same_row && one_trk) ? "R8" : "R7");
      end
    end
    idle(LEN + 4);

    check(recvd == sent, "R10", "blocks delivered", recvd, sent);
    check(out_idx == 0, "R10", "no partial block left", out_idx, 0);
    finish_run();
  end
endmodule